// File: doc/BRIEF.md
# Cache Line Range Maintenance Engine

This engine applies clean or invalidate maintenance to every cache line in an address range, or to a single line. A requester programs a range with two writes on one request port: a range-start write, then a range-end write of the same kind. Only the end write launches work. The engine then walks the selected lines in ascending order and issues one command per line step to the cache's tag/data port. That port uses a valid/acknowledge handshake. While the walk runs, a busy output stalls the requester. A one-cycle done pulse marks completion.

Lines are 32 bytes. A line takes part when its first byte address lies inside the inclusive interval from the start address to the end address. Only the start address is translated upstream, so a range whose two ends lie in different 4 KiB pages is refused with an error pulse. A clean first looks the line up, and it writes the line back only when the cache reports it dirty. An invalidate simply drops the line. The single-line clean+invalidate does both, in that order.

Top module: `cmo_range_engine`

## Requirements
- R1: The lines visited are exactly those whose first byte address (a multiple of 32) lies in [start, end] inclusive. They are visited in ascending order, and each line step is one acknowledged command.
- R2: Request codes on `req_op` are: 1 clean-range start, 2 clean-range end, 3 invalidate-range start, 4 invalidate-range end, 5 line clean, 6 line invalidate, 7 line clean+invalidate, 0 none. A start write only records the address. An end write launches the walk, and it is ignored when no start is pending.
- R3: A later start write replaces the pending start address. An end write whose kind differs from the pending start is ignored, and the pending start is kept.
- R4: `busy` rises the cycle after a launching write and stays high until the final acknowledge. While `busy` is high, request writes are ignored. While `busy` is low, no line command is issued. All outputs are low after reset.
- R5: If start and end differ in address bits above bit 11, the request is refused. `err` pulses for one cycle in the cycle after the end write, no line command is issued, `busy` stays low, and the pending start is dropped.
- R6: If no line qualifies (the last line is below the first line), `busy` is high for exactly one cycle and no command is issued.
- R7: Line command codes on `line_req_cmd` are: 0 lookup, 1 writeback, 2 invalidate. A clean issues a lookup for each line, and a writeback for the same line only when the lookup acknowledge reports `line_dirty`=1.
- R8: An invalidate range issues only an invalidate command for each qualifying line.
- R9: Single-line operations act on the line that contains `req_addr`. Clean is a lookup plus a writeback when dirty. Invalidate is one invalidate. Clean+invalidate is a lookup, a writeback when dirty, then an invalidate.
- R10: `done` is a one-cycle pulse in the first cycle where `busy` is low after a walk.
- R11: A command holds `line_req_valid`, `line_req_addr` and `line_req_cmd` steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request write strobe |
| req_op | input | 3 | Request code (see R2) |
| req_addr | input | ADDR_W | Request address |
| busy | output | 1 | Requester stall while a walk runs |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle page-crossing refusal pulse |
| line_req_valid | output | 1 | Line command valid |
| line_req_cmd | output | 2 | Line command code (see R7) |
| line_req_addr | output | ADDR_W | Line-aligned command address |
| line_ack | input | 1 | Cache accepts the current command |
| line_dirty | input | 1 | With acknowledge of a lookup: line is dirty |

## Verification
The range walk is swept over a grid of start addresses that step through line offsets, combined with end addresses at many distances from each start. This covers aligned and unaligned starts, where the first line is rounded up, and unaligned ends, where the last line is rounded down. It also covers reversed and empty intervals, which separate the inclusive-selection rule from off-by-one variants. The responder's dirty pattern and acknowledge latency vary with the line address, so lookups with and without writebacks are interleaved and handshakes of different lengths occur. Directed sequences cover the order of the two writes, mismatched kinds, replaced starts, page crossing at the page edge, writes arriving during a walk, and each single-line operation on a mid-line address.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    typedef enum logic [2:0] {
        REQ_NONE       = 3'd0,
        REQ_CLN_START  = 3'd1,
        REQ_CLN_END    = 3'd2,
        REQ_INV_START  = 3'd3,
        REQ_INV_END    = 3'd4,
        REQ_LINE_CLN   = 3'd5,
        REQ_LINE_INV   = 3'd6,
        REQ_LINE_FLUSH = 3'd7
    } req_op_e;

    typedef enum logic [1:0] {
        LCMD_LOOKUP = 2'd0,
        LCMD_WRBACK = 2'd1,
        LCMD_INVAL  = 2'd2
    } line_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FIRST  = 3'd1,
        ST_LOOKUP = 3'd2,
        ST_WRBACK = 3'd3,
        ST_INVAL  = 3'd4
    } walk_st_e;

    typedef struct packed {
        logic do_clean;
        logic do_inval;
    } walk_mode_t;

    function automatic walk_mode_t mode_of(req_op_e op);
        walk_mode_t m;
        m.do_clean = (op == REQ_CLN_END) || (op == REQ_LINE_CLN) || (op == REQ_LINE_FLUSH);
        m.do_inval = (op == REQ_INV_END) || (op == REQ_LINE_INV) || (op == REQ_LINE_FLUSH);
        return m;
    endfunction

    function automatic logic is_range_end(req_op_e op);
        return (op == REQ_CLN_END) || (op == REQ_INV_END);
    endfunction

    function automatic logic is_single(req_op_e op);
        return (op == REQ_LINE_CLN) || (op == REQ_LINE_INV) || (op == REQ_LINE_FLUSH);
    endfunction

endpackage

// File: rtl/cmo_cmd_decode.sv
module cmo_cmd_decode
    import cmo_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [2:0]                    req_op,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic                          busy,
    output logic                          launch,
    output walk_mode_t                    launch_mode,
    output logic [ADDR_W-$clog2(LINE_BYTES):0] first_line,
    output logic [ADDR_W-$clog2(LINE_BYTES):0] last_line,
    output logic                          err
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int PG_SH  = $clog2(PAGE_BYTES);
    localparam int LIDX_W = ADDR_W - OFF_W;

    req_op_e             op;
    logic                accept;
    logic                range_fire;
    logic                single_fire;
    logic                kind_match;
    logic                page_cross;
    logic                pend_vld;
    logic                pend_inv;
    logic [ADDR_W-1:0]   pend_addr;
    logic [LIDX_W:0]     start_floor;
    logic [LIDX_W:0]     start_ceil;
    logic [LIDX_W:0]     req_line;

    assign op          = req_op_e'(req_op);
    assign accept      = req_valid && !busy;
    assign kind_match  = pend_vld && (pend_inv == (op == REQ_INV_END));
    assign page_cross  = pend_addr[ADDR_W-1:PG_SH] != req_addr[ADDR_W-1:PG_SH];
    assign range_fire  = accept && is_range_end(op) && kind_match;
    assign single_fire = accept && is_single(op);

    // first qualifying line rounds the start up, last rounds the end down
    assign start_floor = {1'b0, pend_addr[ADDR_W-1:OFF_W]};
    assign start_ceil  = start_floor + {{LIDX_W{1'b0}}, |pend_addr[OFF_W-1:0]};
    assign req_line    = {1'b0, req_addr[ADDR_W-1:OFF_W]};

    assign launch      = (range_fire && !page_cross) || single_fire;
    assign launch_mode = mode_of(op);
    assign first_line  = single_fire ? req_line : start_ceil;
    assign last_line   = req_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_inv  <= 1'b0;
            pend_addr <= '0;
            err       <= 1'b0;
        end else begin
            err <= range_fire && page_cross;
            if (accept && (op == REQ_CLN_START || op == REQ_INV_START)) begin
                pend_vld  <= 1'b1;
                pend_inv  <= (op == REQ_INV_START);
                pend_addr <= req_addr;
            end else if (range_fire) begin
                pend_vld  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmo_line_seq.sv
module cmo_line_seq
    import cmo_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   launch,
    input  walk_mode_t             launch_mode,
    input  logic [ADDR_W-OFF_W:0]  first_line,
    input  logic [ADDR_W-OFF_W:0]  last_line,
    input  logic                   line_ack,
    input  logic                   line_dirty,
    output logic                   busy,
    output logic                   done,
    output logic                   line_req_valid,
    output logic [1:0]             line_req_cmd,
    output logic [ADDR_W-1:0]      line_req_addr
);
    localparam int LIDX_W = ADDR_W - OFF_W;

    walk_st_e          st, st_nx;
    walk_mode_t        mode_q;
    logic [LIDX_W:0]   cur, cur_nx;
    logic [LIDX_W:0]   last_q;
    logic              done_nx;
    walk_st_e          line_entry;
    logic              at_last;

    assign line_entry = mode_q.do_clean ? ST_LOOKUP : ST_INVAL;
    assign at_last    = (cur == last_q);

    always_comb begin
        st_nx   = st;
        cur_nx  = cur;
        done_nx = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (launch) begin
                    st_nx  = ST_FIRST;
                    cur_nx = first_line;
                end
            end
            ST_FIRST: begin
                if (cur > last_q) begin
                    st_nx   = ST_IDLE;
                    done_nx = 1'b1;
                end else begin
                    st_nx = line_entry;
                end
            end
            ST_LOOKUP, ST_WRBACK, ST_INVAL: begin
                if (line_ack) begin
                    if (st == ST_LOOKUP && line_dirty) begin
                        st_nx = ST_WRBACK;
                    end else if (st != ST_INVAL && mode_q.do_inval) begin
                        st_nx = ST_INVAL;
                    end else if (at_last) begin
                        st_nx   = ST_IDLE;
                        done_nx = 1'b1;
                    end else begin
                        cur_nx = cur + 1'b1;
                        st_nx  = line_entry;
                    end
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cur    <= '0;
            last_q <= '0;
            mode_q <= '0;
            done   <= 1'b0;
        end else begin
            st   <= st_nx;
            cur  <= cur_nx;
            done <= done_nx;
            if (st == ST_IDLE && launch) begin
                last_q <= last_line;
                mode_q <= launch_mode;
            end
        end
    end

    assign busy           = (st != ST_IDLE);
    assign line_req_valid = (st == ST_LOOKUP) || (st == ST_WRBACK) || (st == ST_INVAL);
    assign line_req_addr  = {cur[LIDX_W-1:0], {OFF_W{1'b0}}};

    always_comb begin
        unique case (st)
            ST_WRBACK: line_req_cmd = LCMD_WRBACK;
            ST_INVAL:  line_req_cmd = LCMD_INVAL;
            default:   line_req_cmd = LCMD_LOOKUP;
        endcase
    end

endmodule

// File: rtl/cmo_range_engine.sv
module cmo_range_engine
    import cmo_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              line_req_valid,
    output logic [1:0]        line_req_cmd,
    output logic [ADDR_W-1:0] line_req_addr,
    input  logic              line_ack,
    input  logic              line_dirty
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LIDX_W = ADDR_W - OFF_W;

    logic            launch;
    walk_mode_t      launch_mode;
    logic [LIDX_W:0] first_line;
    logic [LIDX_W:0] last_line;

    cmo_cmd_decode #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_decode (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .busy        (busy),
        .launch      (launch),
        .launch_mode (launch_mode),
        .first_line  (first_line),
        .last_line   (last_line),
        .err         (err)
    );

    cmo_line_seq #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_seq (
        .clk            (clk),
        .rst            (rst),
        .launch         (launch),
        .launch_mode    (launch_mode),
        .first_line     (first_line),
        .last_line      (last_line),
        .line_ack       (line_ack),
        .line_dirty     (line_dirty),
        .busy           (busy),
        .done           (done),
        .line_req_valid (line_req_valid),
        .line_req_cmd   (line_req_cmd),
        .line_req_addr  (line_req_addr)
    );

endmodule

// File: rtl/cmo_range_engine_chk.sv
module cmo_range_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              line_req_valid,
    input logic [1:0]        line_req_cmd,
    input logic [ADDR_W-1:0] line_req_addr,
    input logic              line_ack,
    input logic              line_dirty
);
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        line_req_valid && !line_ack |=>
            line_req_valid && $stable(line_req_addr) && $stable(line_req_cmd));

    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line_req_valid);

    p_done_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy && !line_req_valid && !done);

    p_err_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    p_wb_needs_dirty_r7: assert property (@(posedge clk) disable iff (rst)
        line_req_valid && line_req_cmd == 2'd1 && !$past(line_req_valid && line_req_cmd == 2'd1) |->
            $past(line_ack && line_dirty && line_req_cmd == 2'd0));
endmodule

bind cmo_range_engine cmo_range_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cmo_range_engine_bench.sv
module cmo_range_engine_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic          busy, done, err;
    logic          line_req_valid;
    logic [1:0]    line_req_cmd;
    logic [AW-1:0] line_req_addr;
    logic          line_ack = 1'b0;
    logic          line_dirty = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    int        n_log = 0;
    logic [1:0]    log_cmd  [0:1023];
    logic [AW-1:0] log_addr [0:1023];
    int        n_exp = 0;
    logic [1:0]    exp_cmd  [0:1023];
    logic [AW-1:0] exp_addr [0:1023];
    int        hold_viol = 0;

    always #10 clk = ~clk;

    cmo_range_engine #(.ADDR_W(AW)) u_cmo_range_engine (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .busy(busy), .done(done), .err(err),
        .line_req_valid(line_req_valid), .line_req_cmd(line_req_cmd), .line_req_addr(line_req_addr),
        .line_ack(line_ack), .line_dirty(line_dirty)
    );

    function automatic logic dirty_of(logic [AW-1:0] a);
        return a[5] ^ a[8];
    endfunction

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // cache responder and handshake logger
    initial begin
        int wcnt;
        logic          pv;
        logic [1:0]    pc;
        logic [AW-1:0] pa;
        wcnt = 0; pv = 1'b0; pc = '0; pa = '0;
        forever begin
            @(negedge clk);
            if (pv && !line_ack && (!line_req_valid || line_req_cmd != pc || line_req_addr != pa))
                hold_viol++;
            pv = line_req_valid; pc = line_req_cmd; pa = line_req_addr;
            if (line_ack) begin
                line_ack = 1'b0;
                pv = 1'b0;
            end else if (line_req_valid) begin
                if (wcnt >= int'(line_req_addr[7:5]) % 3) begin
                    line_ack   = 1'b1;
                    line_dirty = dirty_of(line_req_addr);
                    if (n_log < 1024) begin
                        log_cmd[n_log]  = line_req_cmd;
                        log_addr[n_log] = line_req_addr;
                    end
                    n_log++;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    task automatic drive(input logic [2:0] op, input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
    endtask

    task automatic build(input logic cln, input logic inv, input longint first, input longint last);
        n_exp = 0;
        for (longint l = first; l <= last; l++) begin
            logic [AW-1:0] a;
            a = AW'(l << 5);
            if (cln) begin
                exp_cmd[n_exp] = 2'd0; exp_addr[n_exp] = a; n_exp++;
                if (dirty_of(a)) begin
                    exp_cmd[n_exp] = 2'd1; exp_addr[n_exp] = a; n_exp++;
                end
            end
            if (inv) begin
                exp_cmd[n_exp] = 2'd2; exp_addr[n_exp] = a; n_exp++;
            end
        end
    endtask

    task automatic compare(input string req);
        int bad;
        int at;
        bad = 0; at = -1;
        check(n_log == n_exp, {req, " command count"}, n_log, n_exp);
        for (int k = 0; k < n_exp && k < n_log; k++) begin
            if (log_cmd[k] != exp_cmd[k] || log_addr[k] != exp_addr[k]) begin
                bad++;
                if (at < 0) at = k;
            end
        end
        if (bad != 0)
            check(1'b0, {req, " command sequence"}, {log_cmd[at], log_addr[at]}, {exp_cmd[at], exp_addr[at]});
        else
            check(1'b1, req, 0, 0);
    endtask

    // wait for walk end; returns busy cycle count; checks done pulse (R10)
    task automatic finish_walk(output int cyc);
        cyc = 1;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        cyc--;
        check(done == 1'b1 && busy == 1'b0, "R10 done when busy falls", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
    endtask

    task automatic run_range(input logic inv, input logic [AW-1:0] s, input logic [AW-1:0] e,
                             input logic intrude);
        longint first, last;
        int cyc;
        n_log = 0;
        drive(inv ? 3'd3 : 3'd1, s);
        drive(inv ? 3'd4 : 3'd2, e);
        if (s[AW-1:12] != e[AW-1:12]) begin
            check(err == 1'b1 && busy == 1'b0, "R5 page cross refused", {err, busy}, 2'b10);
            repeat (3) @(negedge clk);
            check(n_log == 0 && err == 1'b0, "R5 no commands after refusal", n_log, 0);
            drive(inv ? 3'd4 : 3'd2, s);
            check(busy == 1'b0, "R5 pending start dropped", busy, 0);
            return;
        end
        check(busy == 1'b1 && err == 1'b0, "R4 busy after end write", {busy, err}, 2'b10);
        if (intrude) begin
            drive(3'd6, 32'h0000_0F00);
            drive(3'd1, 32'h0000_0040);
        end
        first = (longint'(s) + 31) >>> 5;
        last  = longint'(e) >>> 5;
        build(!inv, inv, first, last);
        finish_walk(cyc);
        if (last < first) check(cyc == 1, "R6 empty range one busy cycle", cyc, 1);
        compare(inv ? "R1 R8 invalidate range" : "R1 R7 clean range");
        if (intrude) begin
            repeat (4) @(negedge clk);
            check(busy == 1'b0 && n_log == n_exp, "R4 writes during walk ignored", n_log, n_exp);
            drive(3'd2, 32'h0000_0060);
            check(busy == 1'b0, "R4 start during walk not recorded", busy, 0);
        end
    endtask

    task automatic run_single(input logic [2:0] op, input logic [AW-1:0] a);
        int cyc;
        n_log = 0;
        drive(op, a);
        check(busy == 1'b1, "R9 single op busy", busy, 1);
        build(op != 3'd6, op != 3'd5, longint'(a) >>> 5, longint'(a) >>> 5);
        finish_walk(cyc);
        compare("R9 single line op");
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && !err && !line_req_valid, "R4 reset outputs quiet",
              {busy, done, err, line_req_valid}, 0);

        // R2: end write with nothing pending
        n_log = 0;
        drive(3'd2, 32'h0000_0100);
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && n_log == 0, "R2 lone end ignored", n_log, 0);

        // R2: start write alone launches nothing
        drive(3'd1, 32'h0000_0100);
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && n_log == 0, "R2 start alone idle", busy, 0);

        // R3: mismatched end ignored, pending kept
        drive(3'd4, 32'h0000_0140);
        repeat (2) @(negedge clk);
        check(busy == 1'b0 && n_log == 0, "R3 mismatched end ignored", busy, 0);
        drive(3'd2, 32'h0000_0140);
        check(busy == 1'b1, "R3 pending start kept", busy, 1);
        build(1'b1, 1'b0, 8, 10);
        finish_walk(cyc);
        compare("R3 walk after kept start");

        // R3: second start replaces
        n_log = 0;
        drive(3'd3, 32'h0000_0000);
        drive(3'd3, 32'h0000_0200);
        drive(3'd4, 32'h0000_0260);
        build(1'b0, 1'b1, 16, 19);
        finish_walk(cyc);
        compare("R3 replaced start");

        // R1/R6 corner ranges
        run_range(1'b0, 32'h0000_0021, 32'h0000_0030, 1'b0); // empty
        run_range(1'b0, 32'h0000_0FE0, 32'h0000_0FFF, 1'b0); // last line of page
        run_range(1'b1, 32'h0000_0FE1, 32'h0000_0FFF, 1'b0); // start rounds into next page
        run_range(1'b1, 32'h0000_0040, 32'h0000_0040, 1'b0); // single line exact
        run_range(1'b0, 32'h0000_0500, 32'h0000_0400, 1'b0); // reversed

        // R5 page cross
        run_range(1'b0, 32'h0000_2FF0, 32'h0000_3010, 1'b0);
        run_range(1'b1, 32'h0001_0000, 32'h0002_0000, 1'b0);

        // R4 requests during walk
        run_range(1'b1, 32'h0000_4000, 32'h0000_43E0, 1'b1);

        // R9 single-line ops on mid-line addresses
        run_single(3'd5, 32'h0000_0133);
        run_single(3'd5, 32'h0000_0101);
        run_single(3'd6, 32'h0000_07FF);
        run_single(3'd7, 32'h0000_0525);
        run_single(3'd7, 32'h0000_0300);

        // sweep over start offsets and lengths
        for (int kind = 0; kind < 2; kind++)
            for (int i = 0; i < 13; i++)
                for (int j = 0; j < 11; j++)
                    run_range(kind[0], 32'h0000_2000 + 32'(i * 9),
                              32'h0000_2000 + 32'(i * 9) + 32'(j * 11) - 32'd3, 1'b0);

        check(hold_viol == 0, "R11 command held until acknowledge", hold_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule